// File: doc/BRIEF.md
# Truth-Table Word Selector

This block routes one of four data words to its output. It does not use a mux tree driven by a select bus. Each output bit reads a 16-entry lookup table, and that table is held in a serial shift register. For bit position b, the four data inputs at position b form the table address: bit k of the address comes from input k. The table contents set the route. With the right pattern loaded, the lookup hands back the address bit of the chosen input. With an all-zero pattern it gives a constant low.

A small loader sets the route. The user presents a 3-bit route code with a one-cycle request while `ready` is high. The loader works out the matching 16-bit pattern and shifts it into every bit's table at once, one pattern bit per clock and most significant bit first. After the sixteenth shift, `ready` rises again. From then on, data flows through the table reads with no clock involved.

The block suits routes that change rarely. The output has no defined meaning while a load is in progress.

Top module: `lutmux_bank`

## Requirements
- R1: During and right after reset, `ready` is high and every tables holds the all-zero pattern, so `dout` is all zeros whatever the data inputs are.
- R2: A `load_req` sampled high on a clock edge while `ready` is high is accepted. `ready` is low after that edge and stays low through the next 15 edges. It is high again after the 16th edge that follows the accepting edge.
- R3: Route codes 0, 1, 2 and 3 select `in0`, `in1`, `in2` and `in3`. Once the load completes, `dout` equals the selected word.
- R4: Route codes 4 to 7 (bit 2 set) disable the block. Once the load completes, `dout` is all zeros for any input values.
- R5: Each new load fully replaces the previous route. Nothing of the earlier pattern remains after the new load.
- R6: A `load_req` that arrives while `ready` is low is ignored. After `ready` returns, the route is still the one from the accepted request.
- R7: All `WIDTH` bit positions receive the same pattern in parallel. Each bit position is routed on its own, using that position's bits of the four inputs.
- R8: While `ready` is high, `dout` follows changes on the data inputs combinationally, within the same clock cycle and without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | Request to load a new route |
| load_code | input | 3 | Route code: 0-3 pick an input, 4-7 disable |
| in0 | input | WIDTH | Data word 0 (table address bit 0) |
| in1 | input | WIDTH | Data word 1 (table address bit 1) |
| in2 | input | WIDTH | Data word 2 (table address bit 2) |
| in3 | input | WIDTH | Data word 3 (table address bit 3) |
| dout | output | WIDTH | Routed word |
| ready | output | 1 | High when no load is in progress |

## Verification
The hardest case to reach from the ports is a second request that lands in the middle of a shift sequence. It can only be exercised when a load is already running and `ready` is low. The stimulus raises `load_req` with a different code on the fifth cycle of a load. It then checks two things:
- the load still takes exactly 16 edges;
- the resulting route is the first code, not the injected one.

Patterns are also checked with data words chosen so that every bit position sees a different 4-bit address. A swapped address bit or a mis-ordered shift would show up as a wrong output bit.

// File: rtl/lutmux_pkg.sv
package lutmux_pkg;
  localparam int TBL_DEPTH = 16;
  localparam int ADDR_W    = $clog2(TBL_DEPTH);
  localparam int CODE_W    = 3;

  typedef logic [TBL_DEPTH-1:0] pattern_t;

  // Entry i of the table is the bit of address i that belongs to the chosen
  // input; a code with bit 2 set yields an all-zero table.
  function automatic pattern_t route_pattern(input logic [CODE_W-1:0] code);
    pattern_t p;
    for (int i = 0; i < TBL_DEPTH; i++) begin
      logic [ADDR_W-1:0] a;
      a    = ADDR_W'(i);
      p[i] = code[2] ? 1'b0 : a[code[1:0]];
    end
    return p;
  endfunction

  function automatic logic route_is_off(input logic [CODE_W-1:0] code);
    return code[2];
  endfunction
endpackage

// File: rtl/lutmux_loader.sv
module lutmux_loader
  import lutmux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [CODE_W-1:0] load_code,
  output logic              shift_en,
  output logic              shift_bit,
  output logic              ready,
  output logic              accept,
  output logic [CODE_W-1:0] active_code
);
  logic              busy;
  logic [ADDR_W-1:0] cnt;
  pattern_t          pat;
  logic [CODE_W-1:0] pend_code;

  assign accept    = load_req & ~busy;
  assign shift_en  = busy;
  assign shift_bit = pat[TBL_DEPTH-1];
  assign ready     = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cnt         <= '0;
      pat         <= '0;
      pend_code   <= 3'b100;
      active_code <= 3'b100;
    end else if (accept) begin
      busy      <= 1'b1;
      cnt       <= '0;
      pat       <= route_pattern(load_code);
      pend_code <= load_code;
    end else if (busy) begin
      pat <= {pat[TBL_DEPTH-2:0], 1'b0};
      cnt <= cnt + 1'b1;
      if (cnt == ADDR_W'(TBL_DEPTH-1)) begin
        busy        <= 1'b0;
        active_code <= pend_code;
      end
    end
  end

  // R1: coming out of reset the loader is idle with the route disabled
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ready && route_is_off(active_code)));

  // R2: an accepted request drops ready on the following cycle
  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && load_req) |=> !ready);

  // R6: requests during a load leave the pending code untouched
  p_ignore_busy_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && load_req) |=> $stable(pend_code));
endmodule

// File: rtl/lutmux_cell.sv
module lutmux_cell
  import lutmux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic [ADDR_W-1:0] addr,
  output logic              y
);
  pattern_t tbl;

  always_ff @(posedge clk) begin
    if (!rst_n)        tbl <= '0;
    else if (shift_en) tbl <= {tbl[TBL_DEPTH-2:0], shift_bit};
  end

  assign y = tbl[addr];

  // R8: a table never changes on the edge after an idle cycle
  p_table_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(tbl));
endmodule

// File: rtl/lutmux_bank.sv
module lutmux_bank
  import lutmux_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [2:0]        load_code,
  input  logic [WIDTH-1:0]  in0,
  input  logic [WIDTH-1:0]  in1,
  input  logic [WIDTH-1:0]  in2,
  input  logic [WIDTH-1:0]  in3,
  output logic [WIDTH-1:0]  dout,
  output logic              ready
);
  localparam int SEEN_W = ADDR_W + 1;

  logic              shift_en;
  logic              shift_bit;
  logic              accept;
  logic [CODE_W-1:0] active_code;

  lutmux_loader u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_req   (load_req),
    .load_code  (load_code),
    .shift_en   (shift_en),
    .shift_bit  (shift_bit),
    .ready      (ready),
    .accept     (accept),
    .active_code(active_code)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    lutmux_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .shift_bit(shift_bit),
      .addr     ({in3[b], in2[b], in1[b], in0[b]}),
      .y        (dout[b])
    );
  end

  // Checker-side shift counter: cleared on accept, counts shift cycles
  logic [SEEN_W-1:0] shifts_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)        shifts_seen <= '0;
    else if (accept)   shifts_seen <= '0;
    else if (shift_en) shifts_seen <= shifts_seen + 1'b1;
  end

  logic [WIDTH-1:0] chosen_word;
  always_comb begin
    unique case (active_code[1:0])
      2'd0:    chosen_word = in0;
      2'd1:    chosen_word = in1;
      2'd2:    chosen_word = in2;
      default: chosen_word = in3;
    endcase
  end

  // R2: each load spans exactly one shift per table entry
  p_load_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (shifts_seen == SEEN_W'(TBL_DEPTH)));

  // R4: a disabled route drives all zeros when idle
  p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && route_is_off(active_code)) |-> (dout == '0));

  // R3: an enabled route presents the chosen word when idle
  p_route_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !route_is_off(active_code)) |-> (dout == chosen_word));
endmodule

// File: tb/tb_lutmux_bank.sv
`timescale 1ns/1ps
module tb_lutmux_bank;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_req = 1'b0;
  logic [2:0]   load_code = 3'd0;
  logic [W-1:0] in0 = '0, in1 = '0, in2 = '0, in3 = '0;
  logic [W-1:0] dout;
  logic         ready;

  lutmux_bank #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_code(load_code),
    .in0(in0), .in1(in1), .in2(in2), .in3(in3), .dout(dout), .ready(ready)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;
  item_t sb[$];
  event  smp;
  logic [2:0] cur_code = 3'd4;

  function automatic logic [W-1:0] expect_word(logic [2:0] c, logic [W-1:0] a,
      logic [W-1:0] b, logic [W-1:0] d2, logic [W-1:0] d3);
    if (c >= 3'd4) return '0;
    if (c == 3'd0) return a;
    if (c == 3'd1) return b;
    if (c == 3'd2) return d2;
    return d3;
  endfunction

  task automatic check1(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: applies inputs away from the clock edge and queues the expectation
  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c,
                       logic [W-1:0] d, string tag);
    item_t it;
    @(negedge clk);
    in0 = a; in1 = b; in2 = c; in3 = d;
    it.exp = expect_word(cur_code, a, b, c, d);
    it.tag = tag;
    sb.push_back(it);
    -> smp;
    #1.5;
  endtask

  // Monitor: pops expectations and compares against the port
  initial begin
    forever begin
      item_t it;
      @(smp);
      #1;
      it = sb.pop_front();
      check1(it.tag, 32'(dout), 32'(it.exp));
    end
  end

  task automatic do_load(logic [2:0] code, bit inject, logic [2:0] junk, string tag);
    int n;
    @(negedge clk);
    load_req = 1'b1; load_code = code;
    @(posedge clk); #1;
    load_req = 1'b0;
    check1({tag, " R2 ready low after accept"}, 32'(ready), 32'd0);
    n = 0;
    while (n < 40) begin
      @(posedge clk); #1;
      load_req = 1'b0;
      n++;
      if (ready) break;
      if (inject && n == 5) begin
        load_req = 1'b1; load_code = junk;
      end
    end
    check1({tag, " R2 edges until ready"}, 32'(n), 32'd16);
    cur_code = code;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check1("R1 ready in reset", 32'(ready), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check1("R1 ready after reset", 32'(ready), 32'd1);
    drive(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R1 zero after reset");
    drive(8'hA5, 8'h3C, 8'h0F, 8'hF0, "R1 zero mixed");

    // Address per bit differs across positions (R7)
    do_load(3'd0, 1'b0, 3'd0, "code0");
    drive(8'hA5, 8'h3C, 8'h0F, 8'hF0, "R3 R7 in0 routed");
    drive(8'h5A, 8'hFF, 8'h00, 8'h00, "R3 in0 other");
    drive(8'h33, 8'hFF, 8'h00, 8'h00, "R8 combinational follow");

    do_load(3'd1, 1'b0, 3'd0, "code1");
    drive(8'hA5, 8'h3C, 8'h0F, 8'hF0, "R3 R5 in1 routed");
    do_load(3'd2, 1'b0, 3'd0, "code2");
    drive(8'hA5, 8'h3C, 8'h0F, 8'hF0, "R3 R5 in2 routed");
    drive(8'h00, 8'h00, 8'h96, 8'hFF, "R7 in2 per bit");
    do_load(3'd3, 1'b0, 3'd0, "code3");
    drive(8'hA5, 8'h3C, 8'h0F, 8'hF0, "R3 R5 in3 routed");
    drive(8'hFF, 8'hFF, 8'hFF, 8'h69, "R7 in3 per bit");

    do_load(3'd5, 1'b0, 3'd0, "code5");
    drive(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R4 off all ones");
    drive(8'hA5, 8'h3C, 8'h0F, 8'hF0, "R4 off mixed");
    do_load(3'd4, 1'b0, 3'd0, "code4");
    drive(8'hFF, 8'h00, 8'hFF, 8'h00, "R4 code4 off");

    // Second request mid-load must be ignored
    do_load(3'd2, 1'b1, 3'd0, "inject");
    drive(8'hA5, 8'h3C, 8'h0F, 8'hF0, "R6 first code kept");
    do_load(3'd1, 1'b1, 3'd6, "inject2");
    drive(8'hC3, 8'h5A, 8'h0F, 8'hF0, "R6 not disabled by late req");

    @(negedge clk);
    #2;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule